// File: doc/BRIEF.md
# Flash Status and Write-Protect Controller

This block keeps the status byte of a serial flash device and judges every decoded command that the serial front end hands it. It holds the write-enable latch, the busy flag, two block-protect bits and a status-lock bit. It samples the write-protect pin and tracks a deep power-down state. For each command strobe it answers with a one-cycle accept or reject pulse. Accepted program, erase and status-write commands start a self-timed busy window whose length is a parameter.

The front end raises `cmdStb` for one cycle per command. Read-type commands are strobed once the opcode is known. Modifying commands are strobed when chip select rises on a byte boundary. The strobe carries the opcode, the 17-bit target address and, for a status write, the data byte. The array sequencer starts only on `cmdGo`. The front end serves status reads from `statusByte`, which is always valid, including while the device is busy.

Top module: `flash_guard`

## Requirements
- R1: After reset `statusByte` is 00h and `deepPd` is 0. The byte layout is bit7 status-lock, bits 6:4 always 0, bit3/bit2 protect level (high/low), bit1 write-enable latch, bit0 busy.
- R2: Opcode 06h sets the write-enable latch and opcode 04h clears it. Program (02h), sector erase (20h), block erase (52h/D8h), chip erase (60h/C7h) and status write (01h) are rejected while the latch is 0.
- R3: Protect level 00 guards no address. Level 01 guards the upper half of the array (address bit 16 set). Levels 10 and 11 guard everything. Program, sector erase and block erase aimed at a guarded address are rejected.
- R4: Chip erase is accepted only when the protect level is 00.
- R5: When the status-lock bit is 1 and the sampled write-protect pin is low, status write is rejected. When the pin is high, status write is accepted again.
- R6: An accepted status write loads data bit 7 into the lock bit and data bits 3:2 into the protect level. Status bits 6:4 and 1:0 do not take the data.
- R7: An accepted program, erase or status write holds the busy bit at 1 for exactly its parameter cycle count, starting in the cycle after the strobe. When the busy bit returns to 0, the write-enable latch is 0.
- R8: While busy, only status read (05h) is accepted. Every other opcode, including 06h and 04h, is rejected and leaves the status byte unchanged.
- R9: Opcode B9h enters deep power-down. In that state only ABh is accepted. ABh starts a release that clears `deepPd` after exactly `RES_CYC` cycles.
- R10: Each strobe gets exactly one of `cmdGo` or `cmdRej`, one cycle later. Opcodes outside the command set are rejected.
- R11: A rejected command leaves the write-enable latch, the protect level and the lock bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wpN | input | 1 | Write-protect pin, active low, sampled by one flop |
| cmdStb | input | 1 | One-cycle command strobe from the front end |
| cmdOp | input | 8 | Opcode of the strobed command |
| cmdAddr | input | AW (17) | Target address of the strobed command |
| cmdData | input | 8 | Data byte for a status write |
| cmdGo | output | 1 | Command accepted, one cycle after the strobe |
| cmdRej | output | 1 | Command rejected, one cycle after the strobe |
| statusByte | output | 8 | Current status byte |
| deepPd | output | 1 | Deep power-down state, including the release delay |

## Verification
The embedded properties check these rules on every cycle: the accept and reject pulses are exclusive and follow every strobe; the busy and deep power-down filters reject what they must; the hardware lock refuses status writes; and any fall of the busy bit finds the write-enable latch already clear. The exact length of each busy window and of the release delay can only be shown by the bench's scenarios. The same holds for the decode of the protect levels against real addresses and for the bit-by-bit effect of a status write. The bench compares all of these against a reference model of the status byte.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_FAST = 8'h0B;
  localparam logic [7:0] OP_RDID = 8'h9F;
  localparam logic [7:0] OP_REMS = 8'h90;
  localparam logic [7:0] OP_SE   = 8'h20;
  localparam logic [7:0] OP_BE1  = 8'h52;
  localparam logic [7:0] OP_BE2  = 8'hD8;
  localparam logic [7:0] OP_CE1  = 8'h60;
  localparam logic [7:0] OP_CE2  = 8'hC7;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_DP   = 8'hB9;
  localparam logic [7:0] OP_SIG  = 8'hAB;

  typedef enum logic [2:0] {
    DUR_NONE, DUR_PROG, DUR_SECT, DUR_BLK, DUR_CHIP, DUR_SR
  } durSel_e;

  typedef struct packed {
    logic     setWel;
    logic     clrWel;
    logic     loadSr;
    logic [2:0] srBits;   // {lock, protect[1:0]}
    durSel_e  dur;
    logic     enterDp;
    logic     startRel;
  } strobe_t;

endpackage

// File: rtl/flash_guard_ctrl.sv
module flash_guard_ctrl
  import flash_guard_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wpN,
  input  logic          cmdStb,
  input  logic [7:0]    cmdOp,
  input  logic [AW-1:0] cmdAddr,
  input  logic [7:0]    cmdData,
  input  logic          wel,
  input  logic          wip,
  input  logic [1:0]    bp,
  input  logic          srwd,
  input  logic          deepPd,
  output strobe_t       strb,
  output logic          cmdGo,
  output logic          cmdRej
);

  logic wpSync;
  logic hwLock;
  logic protHit;
  logic accept;
  logic isModify;
  strobe_t nxt;

  always_ff @(posedge clk) begin
    if (!rstN) wpSync <= 1'b1;
    else       wpSync <= wpN;
  end

  assign hwLock = srwd & ~wpSync;

  always_comb begin
    unique case (bp)
      2'b00:   protHit = 1'b0;
      2'b01:   protHit = cmdAddr[AW-1];
      default: protHit = 1'b1;
    endcase
  end

  always_comb begin
    isModify = (cmdOp == OP_PP) || (cmdOp == OP_SE) || (cmdOp == OP_BE1) ||
               (cmdOp == OP_BE2) || (cmdOp == OP_CE1) || (cmdOp == OP_CE2) ||
               (cmdOp == OP_WRSR);
  end

  always_comb begin
    nxt    = '0;
    accept = 1'b0;
    if (deepPd) begin
      accept       = (cmdOp == OP_SIG);
      nxt.startRel = accept;
    end else if (wip) begin
      accept = (cmdOp == OP_RDSR);
    end else begin
      case (cmdOp)
        OP_WREN: begin accept = 1'b1; nxt.setWel = 1'b1; end
        OP_WRDI: begin accept = 1'b1; nxt.clrWel = 1'b1; end
        OP_RDSR, OP_READ, OP_FAST, OP_RDID, OP_REMS, OP_SIG: accept = 1'b1;
        OP_DP:   begin accept = 1'b1; nxt.enterDp = 1'b1; end
        OP_WRSR: begin
          accept     = wel & ~hwLock;
          nxt.loadSr = accept;
          nxt.srBits = {cmdData[7], cmdData[3:2]};
          if (accept) nxt.dur = DUR_SR;
        end
        OP_PP: begin
          accept = wel & ~protHit;
          if (accept) nxt.dur = DUR_PROG;
        end
        OP_SE: begin
          accept = wel & ~protHit;
          if (accept) nxt.dur = DUR_SECT;
        end
        OP_BE1, OP_BE2: begin
          accept = wel & ~protHit;
          if (accept) nxt.dur = DUR_BLK;
        end
        OP_CE1, OP_CE2: begin
          accept = wel & (bp == 2'b00);
          if (accept) nxt.dur = DUR_CHIP;
        end
        default: accept = 1'b0;
      endcase
    end
    if (!cmdStb) begin
      nxt    = '0;
      accept = 1'b0;
    end
  end

  assign strb = nxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdGo  <= 1'b0;
      cmdRej <= 1'b0;
    end else begin
      cmdGo  <= cmdStb & accept;
      cmdRej <= cmdStb & ~accept;
    end
  end

  // R10: exactly one answer per strobe
  p_one_answer_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdGo, cmdRej}));
  p_answer_follows_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmdStb |=> (cmdGo || cmdRej));
  // R8: busy filter
  p_busy_filter_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStb && wip && cmdOp != OP_RDSR) |=> cmdRej);
  // R9: deep power-down filter
  p_deep_filter_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStb && deepPd && cmdOp != OP_SIG) |=> cmdRej);
  // R5: hardware lock on status write
  p_hw_lock_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStb && cmdOp == OP_WRSR && srwd && !wpSync) |=> cmdRej);
  // R2: latch gate on modifying commands
  p_wel_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStb && !wel && isModify) |=> cmdRej);

endmodule

// File: rtl/flash_guard_regs.sv
module flash_guard_regs
  import flash_guard_pkg::*;
#(
  parameter int PROG_CYC = 20,
  parameter int SECT_CYC = 40,
  parameter int BLK_CYC  = 60,
  parameter int CHIP_CYC = 80,
  parameter int SR_CYC   = 10,
  parameter int RES_CYC  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strb,
  output logic       wel,
  output logic       wip,
  output logic [1:0] bp,
  output logic       srwd,
  output logic       deepPd
);

  localparam int MAX_A = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_B = (BLK_CYC > CHIP_CYC) ? BLK_CYC : CHIP_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_D = (MAX_C > SR_CYC) ? MAX_C : SR_CYC;
  localparam int CW    = $clog2(MAX_D + 1);
  localparam int RW    = $clog2(RES_CYC + 1);

  logic [CW-1:0] busyCnt;
  logic [CW-1:0] durLen;
  logic [RW-1:0] relCnt;

  always_comb begin
    case (strb.dur)
      DUR_PROG: durLen = CW'(PROG_CYC);
      DUR_SECT: durLen = CW'(SECT_CYC);
      DUR_BLK:  durLen = CW'(BLK_CYC);
      DUR_CHIP: durLen = CW'(CHIP_CYC);
      DUR_SR:   durLen = CW'(SR_CYC);
      default:  durLen = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wel     <= 1'b0;
      wip     <= 1'b0;
      bp      <= 2'b00;
      srwd    <= 1'b0;
      deepPd  <= 1'b0;
      busyCnt <= '0;
      relCnt  <= '0;
    end else begin
      if (strb.setWel) wel <= 1'b1;
      if (strb.clrWel) wel <= 1'b0;
      if (strb.loadSr) {srwd, bp} <= strb.srBits;

      if (strb.dur != DUR_NONE) begin
        wip     <= 1'b1;
        busyCnt <= durLen;
      end else if (wip) begin
        if (busyCnt == CW'(1)) begin
          wip <= 1'b0;
          wel <= 1'b0;
        end
        busyCnt <= busyCnt - CW'(1);
      end

      if (strb.enterDp) deepPd <= 1'b1;
      if (relCnt != '0) begin
        if (relCnt == RW'(1)) deepPd <= 1'b0;
        relCnt <= relCnt - RW'(1);
      end
      if (strb.startRel) relCnt <= RW'(RES_CYC);
    end
  end

  // R7: the latch is clear whenever the busy window ends
  p_wel_at_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> !wel);
  // R7: the busy window opens only on a timed strobe from the control
  p_wip_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> $past(strb.dur != DUR_NONE));
  // R9: release only runs out of deep power-down
  p_release_from_deep_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(deepPd) |-> $past(relCnt == RW'(1)));

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int AW       = 17,
  parameter int PROG_CYC = 20,
  parameter int SECT_CYC = 40,
  parameter int BLK_CYC  = 60,
  parameter int CHIP_CYC = 80,
  parameter int SR_CYC   = 10,
  parameter int RES_CYC  = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wpN,
  input  logic          cmdStb,
  input  logic [7:0]    cmdOp,
  input  logic [AW-1:0] cmdAddr,
  input  logic [7:0]    cmdData,
  output logic          cmdGo,
  output logic          cmdRej,
  output logic [7:0]    statusByte,
  output logic          deepPd
);

  strobe_t    strb;
  logic       wel;
  logic       wip;
  logic [1:0] bp;
  logic       srwd;

  flash_guard_ctrl #(.AW(AW)) uCtrl (
    .clk(clk), .rstN(rstN), .wpN(wpN), .cmdStb(cmdStb), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .wel(wel), .wip(wip), .bp(bp),
    .srwd(srwd), .deepPd(deepPd), .strb(strb), .cmdGo(cmdGo), .cmdRej(cmdRej)
  );

  flash_guard_regs #(
    .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .BLK_CYC(BLK_CYC),
    .CHIP_CYC(CHIP_CYC), .SR_CYC(SR_CYC), .RES_CYC(RES_CYC)
  ) uRegs (
    .clk(clk), .rstN(rstN), .strb(strb), .wel(wel), .wip(wip), .bp(bp),
    .srwd(srwd), .deepPd(deepPd)
  );

  assign statusByte = {srwd, 3'b000, bp, wel, wip};

endmodule

// File: tb/tb_flash_guard.sv
`timescale 1ns/1ps
module tb_flash_guard;

  localparam int PROG_CYC = 20;
  localparam int SECT_CYC = 40;
  localparam int BLK_CYC  = 60;
  localparam int CHIP_CYC = 80;
  localparam int SR_CYC   = 10;
  localparam int RES_CYC  = 8;

  localparam logic [7:0] WREN = 8'h06, WRDI = 8'h04, RDSR = 8'h05, WRSR = 8'h01;
  localparam logic [7:0] READ = 8'h03, FAST = 8'h0B, RDID = 8'h9F, REMS = 8'h90;
  localparam logic [7:0] SE = 8'h20, BE1 = 8'h52, BE2 = 8'hD8, CE1 = 8'h60;
  localparam logic [7:0] CE2 = 8'hC7, PP = 8'h02, DP = 8'hB9, SIG = 8'hAB;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wpN = 1'b1;
  logic        cmdStb = 1'b0;
  logic [7:0]  cmdOp = 8'h00;
  logic [16:0] cmdAddr = '0;
  logic [7:0]  cmdData = 8'h00;
  logic        cmdGo, cmdRej, deepPd;
  logic [7:0]  statusByte;

  int total = 0;
  int fails = 0;

  bit       mWel = 0, mSrwd = 0, mDeep = 0, mBusy = 0, mWp = 1;
  bit [1:0] mBp = 2'b00;

  always #5 clk = ~clk;

  flash_guard #(
    .AW(17), .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .BLK_CYC(BLK_CYC),
    .CHIP_CYC(CHIP_CYC), .SR_CYC(SR_CYC), .RES_CYC(RES_CYC)
  ) dut (
    .clk(clk), .rstN(rstN), .wpN(wpN), .cmdStb(cmdStb), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .cmdGo(cmdGo), .cmdRej(cmdRej),
    .statusByte(statusByte), .deepPd(deepPd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit [7:0] expStatus();
    return {mSrwd, 3'b000, mBp, mWel, mBusy};
  endfunction

  function automatic bit isGuarded(input logic [16:0] a);
    if (mBp == 2'b00) return 1'b0;
    if (mBp == 2'b01) return a[16];
    return 1'b1;
  endfunction

  function automatic bit expectGo(input logic [7:0] op, input logic [16:0] a);
    if (mDeep) return op == SIG;
    if (mBusy) return op == RDSR;
    case (op)
      WREN, WRDI, RDSR, READ, FAST, RDID, REMS, SIG, DP: return 1'b1;
      WRSR:          return mWel && !(mSrwd && !mWp);
      PP, SE, BE1, BE2: return mWel && !isGuarded(a);
      CE1, CE2:      return mWel && (mBp == 2'b00);
      default:       return 1'b0;
    endcase
  endfunction

  function automatic int durOf(input logic [7:0] op);
    case (op)
      PP:       return PROG_CYC;
      SE:       return SECT_CYC;
      BE1, BE2: return BLK_CYC;
      CE1, CE2: return CHIP_CYC;
      WRSR:     return SR_CYC;
      default:  return 0;
    endcase
  endfunction

  task automatic setWp(input bit lvl);
    @(negedge clk);
    wpN = lvl;
    mWp = lvl;
    @(negedge clk);
  endtask

  task automatic waitIdle(input string req);
    int n = 0;
    while (statusByte[0] && n < 1000) begin n++; @(negedge clk); end
    mBusy = 0;
    mWel  = 0;
    chk(statusByte == expStatus(), req, statusByte, expStatus());
  endtask

  task automatic doCmd(input logic [7:0] op, input logic [16:0] a,
                       input logic [7:0] d, input string req, input bit waitDone = 1'b1);
    bit eGo;
    bit wasDeep;
    int dur;
    int n;
    eGo     = expectGo(op, a);
    wasDeep = mDeep;
    dur     = (eGo && !mDeep && !mBusy) ? durOf(op) : 0;
    @(negedge clk);
    cmdOp = op; cmdAddr = a; cmdData = d; cmdStb = 1'b1;
    @(negedge clk);
    cmdStb = 1'b0;
    chk({cmdGo, cmdRej} == {eGo, !eGo}, req, {cmdGo, cmdRej}, {eGo, !eGo});
    if (eGo && !wasDeep && !mBusy) begin
      case (op)
        WREN: mWel = 1;
        WRDI: mWel = 0;
        DP:   mDeep = 1;
        WRSR: begin mSrwd = d[7]; mBp = d[3:2]; end
        default: ;
      endcase
    end
    if (dur > 0) begin
      // R6/R7: new protect bits visible, latch still set, busy up
      chk(statusByte == {mSrwd, 3'b000, mBp, 1'b1, 1'b1}, req, statusByte,
          {mSrwd, 3'b000, mBp, 1'b1, 1'b1});
      if (!waitDone) begin mBusy = 1; return; end
      n = 0;
      while (statusByte[0] && n < 1000) begin n++; @(negedge clk); end
      chk(n == dur, "R7 busy length", n, dur);
      mWel = 0;
    end
    if (eGo && wasDeep && op == SIG) begin
      n = 0;
      while (deepPd && n < 1000) begin n++; @(negedge clk); end
      chk(n == RES_CYC, "R9 release delay", n, RES_CYC);
      mDeep = 0;
    end
    chk(statusByte == expStatus(), req, statusByte, expStatus());
    chk(deepPd == mDeep, req, deepPd, mDeep);
  endtask

  initial begin
    #(150000 * 10);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] ops [16];
    ops = '{WREN, WRDI, RDSR, WRSR, READ, FAST, RDID, REMS,
            SE, BE1, BE2, CE1, CE2, PP, DP, SIG};
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(statusByte == 8'h00, "R1 reset status", statusByte, 0);
    chk(deepPd == 1'b0, "R1 reset deep", deepPd, 0);
    chk({cmdGo, cmdRej} == 2'b00, "R1 reset answers", {cmdGo, cmdRej}, 0);

    // R2/R11: modifying without latch
    doCmd(PP, 17'h00100, 8'h00, "R2 PP without latch");
    doCmd(WRSR, 17'h0, 8'h8C, "R11 WRSR without latch");
    doCmd(WREN, 17'h0, 8'h00, "R2 set latch");
    doCmd(WRDI, 17'h0, 8'h00, "R2 clear latch");
    doCmd(CE1, 17'h0, 8'h00, "R2 CE without latch");

    // R6: status write takes only bits 7,3,2
    doCmd(WREN, 17'h0, 8'h00, "R2 set latch");
    doCmd(WRSR, 17'h0, 8'hFF, "R6 WRSR all ones");

    // R5: hardware lock
    setWp(1'b0);
    doCmd(WREN, 17'h0, 8'h00, "R2 set latch");
    doCmd(WRSR, 17'h0, 8'h00, "R5 locked WRSR");
    setWp(1'b1);
    doCmd(WRSR, 17'h0, 8'h84, "R5 unlocked WRSR");

    // R3/R4: level 01 guards upper half
    doCmd(WREN, 17'h0, 8'h00, "R2 set latch");
    doCmd(PP, 17'h10000, 8'h00, "R3 PP upper guarded");
    doCmd(SE, 17'h1F000, 8'h00, "R3 SE upper guarded");
    doCmd(CE2, 17'h0, 8'h00, "R4 CE with level 01");
    doCmd(PP, 17'h0FFFF, 8'h00, "R3 PP lower open");
    doCmd(WREN, 17'h0, 8'h00, "R2 set latch");
    doCmd(BE2, 17'h00000, 8'h00, "R3 BE lower open");
    doCmd(WREN, 17'h0, 8'h00, "R2 set latch");
    doCmd(WRSR, 17'h0, 8'h08, "R6 set level 10");
    doCmd(WREN, 17'h0, 8'h00, "R2 set latch");
    doCmd(SE, 17'h00010, 8'h00, "R3 SE all guarded");
    doCmd(CE1, 17'h0, 8'h00, "R4 CE with level 10");
    doCmd(WRSR, 17'h0, 8'h00, "R6 clear level");
    doCmd(WREN, 17'h0, 8'h00, "R2 set latch");
    doCmd(CE1, 17'h0, 8'h00, "R4 CE with level 00");

    // R8: busy filter
    doCmd(WREN, 17'h0, 8'h00, "R2 set latch");
    doCmd(PP, 17'h00200, 8'h00, "R7 PP start", 1'b0);
    doCmd(READ, 17'h0, 8'h00, "R8 READ while busy");
    doCmd(WRDI, 17'h0, 8'h00, "R8 WRDI while busy");
    doCmd(RDID, 17'h0, 8'h00, "R8 RDID while busy");
    doCmd(RDSR, 17'h0, 8'h00, "R8 RDSR while busy");
    waitIdle("R7 latch clear after busy");

    // R9: deep power-down
    doCmd(WREN, 17'h0, 8'h00, "R2 set latch");
    doCmd(DP, 17'h0, 8'h00, "R9 enter deep");
    doCmd(WRDI, 17'h0, 8'h00, "R9 WRDI in deep");
    doCmd(RDSR, 17'h0, 8'h00, "R9 RDSR in deep");
    doCmd(SIG, 17'h0, 8'h00, "R9 release");

    // R10: unknown opcode
    doCmd(8'hFF, 17'h0, 8'h00, "R10 unknown opcode");
    doCmd(8'h00, 17'h0, 8'h00, "R10 unknown opcode");

    // random mix
    for (int i = 0; i < 250; i++) begin
      logic [7:0] op;
      if ($urandom_range(0, 9) == 0) setWp(1'($urandom_range(0, 1)));
      op = ($urandom_range(0, 3) == 0) ? WREN : ops[$urandom_range(0, 15)];
      doCmd(op, 17'($urandom), 8'($urandom), "R10 random mix");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule